// File: doc/BRIEF.md
# Next Program Counter Selection Unit

This block chooses the program counter value for the next instruction of a word-addressed processor. Each enabled clock cycle it takes the current PC and a transfer mode and forms one candidate target. The modes are: step to the next word, load an absolute target from the instruction, load a 16-bit pointer, load a pointer widened by a high-address extension register, or add a signed 12-bit offset to the PC. The selected value is stored in an output register.

The surrounding pipeline feeds the registered value back as the current PC. It drives the mode from its decoder and the enable from its own advance condition. Return-address handling, stalls and decode are done outside the block.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset sets `next_pc` to zero at the next clock edge, whatever the other inputs are.
- R2: While `en` is low and reset is low, `next_pc` keeps its value across clock edges.
- R3: With mode code 0 (sequential), the edge loads `cur_pc + 1`, wrapping modulo 2^22, so 0x3FFFFF becomes 0.
- R4: With mode code 1 (absolute), the edge loads the 22-bit `imm` field unchanged.
- R5: With mode code 2 (indirect), the edge loads `ptr` in bits 15:0 and zeros in bits 21:16, and `ext` has no effect.
- R6: With mode code 3 (extended indirect), the edge loads `ext` into bits 21:16 and `ptr` into bits 15:0.
- R7: With mode code 4 (relative), the edge loads `cur_pc + sext(rel_ofs) + 1` modulo 2^22. `rel_ofs` is 12-bit two's complement covering -2048 to 2047.
- R8: Mode codes 5, 6 and 7 behave exactly like the sequential mode.
- R9: `next_pc` changes only at a rising clock edge. It reflects the inputs sampled at that edge and takes effect one cycle after they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable for the PC register |
| mode | input | 3 | Transfer mode code (0 seq, 1 abs, 2 ind, 3 ext ind, 4 rel) |
| cur_pc | input | 22 | Current program counter, in words |
| imm | input | 22 | Absolute target carried by the instruction |
| ptr | input | 16 | Pointer register value |
| ext | input | 6 | High-address extension register |
| rel_ofs | input | 12 | Signed relative offset |
| next_pc | output | 22 | Registered next program counter |

## Verification
The in-RTL assertions check the following on every cycle: the value right after reset, holding while disabled, the sequential and absolute loads, the cleared upper bits in indirect mode, the extension bits in extended indirect mode, and the identity of the relative adder at offset -1. Other behaviour shows up only in the bench's scenarios. That includes relative arithmetic at both offset extremes, wrap-around at the top and bottom of the PC space, unused mode codes falling back to sequential, and long random mixes of modes. The bench compares each of these against its own model.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int NPC_PC_W  = 22;
  localparam int NPC_PTR_W = 16;
  localparam int NPC_OFS_W = 12;
  localparam int NPC_MODE_W = 3;

  typedef enum logic [NPC_MODE_W-1:0] {
    NPC_SEQ = 3'd0,
    NPC_ABS = 3'd1,
    NPC_IND = 3'd2,
    NPC_XIND = 3'd3,
    NPC_REL = 3'd4
  } npc_mode_e;
endpackage

// File: rtl/npc_rel_adder.sv
module npc_rel_adder #(
  parameter int PC_W  = 22,
  parameter int OFS_W = 12
) (
  input  logic [PC_W-1:0]  base,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  sum
);
  localparam int SX_W = PC_W - OFS_W;

  logic [PC_W-1:0] ofs_sx;
  logic [PC_W-1:0] one;

  generate
    if (SX_W > 0) begin : g_sext
      assign ofs_sx = {{SX_W{ofs[OFS_W-1]}}, ofs};
    end else begin : g_trunc
      assign ofs_sx = ofs[PC_W-1:0];
    end
  endgenerate

  assign one = {{(PC_W-1){1'b0}}, 1'b1};
  assign sum = base + ofs_sx + one;

  // R7: an offset of -1 cancels the implicit +1
  always_comb begin
    if (ofs == {OFS_W{1'b1}}) begin
      a_r7_minus_one_identity: assert (sum == base);
    end
  end
endmodule

// File: rtl/npc_target_mux.sv
module npc_target_mux
  import npc_pkg::*;
#(
  parameter int PC_W  = 22,
  parameter int PTR_W = 16
) (
  input  logic [NPC_MODE_W-1:0] mode,
  input  logic [PC_W-1:0]       seq_pc,
  input  logic [PC_W-1:0]       rel_pc,
  input  logic [PC_W-1:0]       imm,
  input  logic [PTR_W-1:0]      ptr,
  input  logic [PC_W-PTR_W-1:0] ext,
  output logic [PC_W-1:0]       target
);
  localparam int HI_W = PC_W - PTR_W;

  logic [PC_W-1:0] ind_pc;
  logic [PC_W-1:0] xind_pc;

  generate
    if (HI_W > 0) begin : g_wide
      assign ind_pc  = {{HI_W{1'b0}}, ptr};
      assign xind_pc = {ext, ptr};
    end else begin : g_narrow
      assign ind_pc  = ptr[PC_W-1:0];
      assign xind_pc = ptr[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    case (mode)
      NPC_ABS:  target = imm;
      NPC_IND:  target = ind_pc;
      NPC_XIND: target = xind_pc;
      NPC_REL:  target = rel_pc;
      default:  target = seq_pc;
    endcase
  end

  // R5: indirect target never carries extension bits
  always_comb begin
    if (mode == NPC_IND) begin
      a_r5_ind_zero_hi: assert (target[PC_W-1:PTR_W] == '0);
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int PC_W  = NPC_PC_W,
  parameter int PTR_W = NPC_PTR_W,
  parameter int OFS_W = NPC_OFS_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [NPC_MODE_W-1:0] mode,
  input  logic [PC_W-1:0]       cur_pc,
  input  logic [PC_W-1:0]       imm,
  input  logic [PTR_W-1:0]      ptr,
  input  logic [PC_W-PTR_W-1:0] ext,
  input  logic [OFS_W-1:0]      rel_ofs,
  output logic [PC_W-1:0]       next_pc
);
  localparam int HI_W = PC_W - PTR_W;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] pc_q;

  npc_rel_adder #(.PC_W(PC_W), .OFS_W(OFS_W)) u_seq (
    .base(cur_pc), .ofs({OFS_W{1'b0}}), .sum(seq_pc)
  );

  npc_rel_adder #(.PC_W(PC_W), .OFS_W(OFS_W)) u_rel (
    .base(cur_pc), .ofs(rel_ofs), .sum(rel_pc)
  );

  npc_target_mux #(.PC_W(PC_W), .PTR_W(PTR_W)) u_mux (
    .mode(mode), .seq_pc(seq_pc), .rel_pc(rel_pc),
    .imm(imm), .ptr(ptr), .ext(ext), .target(target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (en) begin
      pc_q <= target;
    end
  end

  assign next_pc = pc_q;

  // R1: value right after reset is zero
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> next_pc == '0);

  // R2: disabled cycles hold the register
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(next_pc));

  // R3: sequential step
  a_r3_seq_step: assert property (@(posedge clk) disable iff (rst)
    (en && mode == NPC_SEQ) |=> next_pc == $past(cur_pc) + 1'b1);

  // R4: absolute load
  a_r4_abs_load: assert property (@(posedge clk) disable iff (rst)
    (en && mode == NPC_ABS) |=> next_pc == $past(imm));

  // R6: extension register fills the upper bits
  a_r6_xind_hi: assert property (@(posedge clk) disable iff (rst)
    (en && mode == NPC_XIND) |=> next_pc[PC_W-1:PTR_W] == $past(ext));

  // R5: indirect load zero-extends the pointer
  a_r5_ind_load: assert property (@(posedge clk) disable iff (rst)
    (en && mode == NPC_IND) |=> next_pc == {{HI_W{1'b0}}, $past(ptr)});
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  localparam int PC_W = 22;
  localparam int MASK = (1 << PC_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [2:0]  mode = '0;
  logic [21:0] cur_pc = '0;
  logic [21:0] imm = '0;
  logic [15:0] ptr = '0;
  logic [5:0]  ext = '0;
  logic [11:0] rel_ofs = '0;
  logic [21:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .cur_pc(cur_pc),
    .imm(imm), .ptr(ptr), .ext(ext), .rel_ofs(rel_ofs), .next_pc(next_pc)
  );

  function automatic int model(input int m, input int pc, input int im,
                               input int p, input int x, input int ofs);
    int sofs;
    sofs = (ofs >= 2048) ? ofs - 4096 : ofs;
    case (m)
      1: return im & MASK;
      2: return p & 16'hFFFF;
      3: return ((x & 6'h3F) << 16) | (p & 16'hFFFF);
      4: return (pc + sofs + 1) & MASK;
      default: return (pc + 1) & MASK;
    endcase
  endfunction

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(next_pc) != exp) begin
      errors++;
      $display("FAIL %s: got 0x%06h expected 0x%06h", req, next_pc, exp);
    end
  endtask

  // apply inputs at negedge, sample at next negedge (one edge later)
  task automatic step(input string req, input int m, input int pc,
                      input int im, input int p, input int x, input int ofs);
    int exp;
    mode = 3'(m); cur_pc = 22'(pc); imm = 22'(im); ptr = 16'(p);
    ext = 6'(x); rel_ofs = 12'(ofs); en = 1'b1;
    exp = model(m, pc, im, p, x, ofs);
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int held;
    void'($urandom(32'd1234));
    mode = 3'd1; imm = 22'h155555; en = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset zero", 0);

    rst = 1'b0;
    step("R4 absolute", 1, 22'h000100, 22'h2ABCDE, 0, 0, 0);
    // R2: disabled hold
    held = int'(next_pc);
    en = 1'b0; mode = 3'd1; imm = 22'h000777;
    @(negedge clk); @(negedge clk);
    check("R2 hold", held);

    step("R3 seq", 0, 22'h001234, 0, 0, 0, 0);
    step("R3 seq wrap", 0, 22'h3FFFFF, 0, 0, 0, 0);
    step("R5 indirect ext ignored", 2, 22'h000010, 0, 16'hBEEF, 6'h3F, 0);
    step("R6 ext indirect max", 3, 0, 0, 16'hFFFF, 6'h3F, 0);
    step("R6 ext indirect", 3, 0, 0, 16'h1234, 6'h15, 0);
    step("R7 rel max", 4, 22'h001000, 0, 0, 0, 12'h7FF);
    step("R7 rel min", 4, 22'h001000, 0, 0, 0, 12'h800);
    step("R7 rel wrap low", 4, 0, 0, 0, 0, 12'h800);
    step("R7 rel wrap high", 4, 22'h3FFFFF, 0, 0, 0, 12'h7FF);
    step("R7 rel minus one", 4, 22'h012345, 0, 0, 0, 12'hFFF);
    step("R8 code5", 5, 22'h000ABC, 22'h3FFFFF, 16'h1, 6'h1, 12'h7FF);
    step("R8 code6", 6, 22'h000ABC, 22'h3FFFFF, 16'h1, 6'h1, 12'h7FF);
    step("R8 code7", 7, 22'h3FFFFF, 22'h000001, 16'h1, 6'h1, 12'h001);

    // R9: an input change mid-cycle does not alter the output before the edge
    held = int'(next_pc);
    mode = 3'd1; imm = 22'h0F0F0F; en = 1'b1;
    #3;
    check("R9 no change before edge", held);
    @(negedge clk);
    check("R9 update at edge", 22'h0F0F0F);

    for (int i = 0; i < 400; i++) begin
      int m;
      m = int'($urandom_range(0, 7));
      step("R3-R8 random mix", m, int'($urandom) & MASK, int'($urandom) & MASK,
           int'($urandom) & 16'hFFFF, int'($urandom) & 6'h3F,
           int'($urandom) & 12'hFFF);
    end

    // R1 mid-run reset
    rst = 1'b1; mode = 3'd1; imm = 22'h123456;
    @(negedge clk);
    check("R1 reset mid run", 0);
    rst = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule